// File: doc/BRIEF.md
# Bufferless Router Local Access Stage

This stage sits in front of the permutation network of a bufferless deflection router. Each cycle it receives the flits on the four incoming link slots. It takes out at most one flit addressed to this node and sends it to the local reassembly side. If a slot is empty after that removal, it places one new flit from the local injection FIFO into that slot. The four resulting slots and the ejected flit are registered, so everything this stage decides appears one clock later.

Ejection always serves a golden flit first, so the one packet that must make progress is never held back by ordinary local traffic. New traffic has the lowest priority. Injection uses only slots that are empty after ejection and never replaces a flit that is already in the network. Local flits that lose the ejection contest stay in their slots and travel on; the network then deflects them.

Top module: `bdr_inject_eject`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output slot reads as all zeros and `ej_valid` is 0.
- R2: A slot flit is laid out as {valid at bit FW-1, golden at bit FW-2, destination at bits [PW+DW-1:PW], payload at bits [PW-1:0]}, with slot k at bits [k*FW +: FW]. A valid flit whose destination differs from `HOME_ID` appears unchanged in the same output slot one cycle later.
- R3: A valid flit whose destination equals `HOME_ID`, when chosen for ejection, appears on `ej_flit` with `ej_valid` high one cycle later. Its output slot is then empty (all zeros) unless an injected flit fills it.
- R4: At most one flit is ejected per cycle. Every local flit that is not ejected appears unchanged in its own output slot one cycle later.
- R5: If any local flit has its golden bit set, the ejected flit is a golden one.
- R6: Among candidates of equal rank (all golden or all non-golden), the lowest-numbered input slot is ejected.
- R7: When `ej_ready` is low, nothing is ejected: `ej_valid` is 0 the next cycle and every input slot passes through unchanged.
- R8: When `inj_avail` is high and at least one slot is empty after ejection, `inj_pop` is high in that same cycle. The FIFO flit appears one cycle later in the lowest-numbered such slot, with its valid bit forced to 1 and all other fields kept.
- R9: When all four slots hold flits that stay in the network, `inj_pop` is low and no flit is displaced.
- R10: When `inj_avail` is low, `inj_pop` is low, and any slot that is empty after ejection is output as all zeros.
- R11: An `ej_flit` value is all zeros whenever `ej_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_flits | input | NP*FW | Flits arriving on the link slots |
| inj_avail | input | 1 | Injection FIFO holds a flit |
| inj_flit | input | FW | Head flit of the injection FIFO (its valid bit is ignored) |
| inj_pop | output | 1 | Pops the injection FIFO this cycle |
| ej_ready | input | 1 | Reassembly side can accept a flit |
| ej_valid | output | 1 | `ej_flit` holds an ejected flit |
| ej_flit | output | FW | Ejected flit |
| out_flits | output | NP*FW | Slots handed to the permutation network |

## Verification
On every cycle, the assertions check that at most one slot is ejected, that ejection waits for `ej_ready`, that a golden local flit wins ejection, that injection lands only in a slot that is free after ejection, and that the number of valid flits is conserved across the stage (flits in, minus the one ejected, plus the one injected). Payload integrity, the lowest-slot tie-break, where the injected flit lands and the zeroing of emptied slots can be seen only by comparing whole flits. The bench does this by sweeping every combination of empty, remote, local and golden-local states over the four slots, together with both values of `ej_ready` and `inj_avail`.

// File: rtl/bdr_ie_pkg.sv
package bdr_ie_pkg;

  typedef enum logic [1:0] {
    EJK_NONE  = 2'd0,
    EJK_GOLD  = 2'd1,
    EJK_PLAIN = 2'd2
  } ej_kind_e;

  function automatic int flit_width(input int dest_w, input int pay_w);
    return 2 + dest_w + pay_w;
  endfunction

endpackage

// File: rtl/bdr_eject_pick.sv
module bdr_eject_pick
  import bdr_ie_pkg::*;
#(
  parameter int NP      = 4,
  parameter int DW      = 6,
  parameter int PW      = 16,
  parameter int HOME_ID = 5,
  localparam int FW     = flit_width(DW, PW)
) (
  input  logic [NP*FW-1:0] in_flits,
  input  logic             ej_ready,
  output logic [NP-1:0]    local_vec,
  output logic [NP-1:0]    gold_vec,
  output logic [NP-1:0]    eject_sel,
  output ej_kind_e         ej_kind,
  output logic [FW-1:0]    ej_flit_c
);

  localparam logic [DW-1:0] HOME = DW'(HOME_ID);

  logic [NP-1:0] gold_local;
  logic [NP-1:0] cand;

  for (genvar k = 0; k < NP; k++) begin : g_slot
    logic          v;
    logic [DW-1:0] d;
    assign v            = in_flits[k*FW + FW - 1];
    assign gold_vec[k]  = in_flits[k*FW + FW - 2];
    assign d            = in_flits[k*FW + PW +: DW];
    assign local_vec[k] = v && (d == HOME);
  end

  assign gold_local = local_vec & gold_vec;
  assign cand       = (|gold_local) ? gold_local : local_vec;
  assign eject_sel  = ej_ready ? (cand & (~cand + NP'(1))) : '0;

  always_comb begin
    if (!(|eject_sel))       ej_kind = EJK_NONE;
    else if (|gold_local)    ej_kind = EJK_GOLD;
    else                     ej_kind = EJK_PLAIN;
  end

  always_comb begin
    ej_flit_c = '0;
    for (int k = 0; k < NP; k++) begin
      if (eject_sel[k]) ej_flit_c = ej_flit_c | in_flits[k*FW +: FW];
    end
  end

endmodule

// File: rtl/bdr_inject_fill.sv
module bdr_inject_fill
  import bdr_ie_pkg::*;
#(
  parameter int NP  = 4,
  parameter int DW  = 6,
  parameter int PW  = 16,
  localparam int FW = flit_width(DW, PW)
) (
  input  logic [NP*FW-1:0] in_flits,
  input  logic [NP-1:0]    eject_sel,
  input  logic             inj_avail,
  input  logic [FW-1:0]    inj_flit,
  output logic [NP-1:0]    vacancy,
  output logic [NP-1:0]    inject_sel,
  output logic             inj_pop,
  output logic [NP*FW-1:0] nxt_flits
);

  logic [NP-1:0] free_lo;
  logic [FW-1:0] placed;

  assign placed = {1'b1, inj_flit[FW-2:0]};

  for (genvar k = 0; k < NP; k++) begin : g_vac
    assign vacancy[k] = !in_flits[k*FW + FW - 1] || eject_sel[k];
  end

  assign free_lo    = vacancy & (~vacancy + NP'(1));
  assign inject_sel = inj_avail ? free_lo : '0;
  assign inj_pop    = |inject_sel;

  for (genvar k = 0; k < NP; k++) begin : g_out
    always_comb begin
      if (inject_sel[k])   nxt_flits[k*FW +: FW] = placed;
      else if (vacancy[k]) nxt_flits[k*FW +: FW] = '0;
      else                 nxt_flits[k*FW +: FW] = in_flits[k*FW +: FW];
    end
  end

endmodule

// File: rtl/bdr_inject_eject.sv
module bdr_inject_eject
  import bdr_ie_pkg::*;
#(
  parameter int NP      = 4,
  parameter int DW      = 6,
  parameter int PW      = 16,
  parameter int HOME_ID = 5,
  localparam int FW     = flit_width(DW, PW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP*FW-1:0] in_flits,
  input  logic             inj_avail,
  input  logic [FW-1:0]    inj_flit,
  output logic             inj_pop,
  input  logic             ej_ready,
  output logic             ej_valid,
  output logic [FW-1:0]    ej_flit,
  output logic [NP*FW-1:0] out_flits
);

  logic [NP-1:0]    local_vec;
  logic [NP-1:0]    gold_vec;
  logic [NP-1:0]    eject_sel;
  logic [NP-1:0]    vacancy;
  logic [NP-1:0]    inject_sel;
  ej_kind_e         ej_kind;
  logic [FW-1:0]    ej_flit_c;
  logic [NP*FW-1:0] nxt_flits;

  bdr_eject_pick #(.NP(NP), .DW(DW), .PW(PW), .HOME_ID(HOME_ID)) u_pick (
    .in_flits (in_flits),
    .ej_ready (ej_ready),
    .local_vec(local_vec),
    .gold_vec (gold_vec),
    .eject_sel(eject_sel),
    .ej_kind  (ej_kind),
    .ej_flit_c(ej_flit_c)
  );

  bdr_inject_fill #(.NP(NP), .DW(DW), .PW(PW)) u_fill (
    .in_flits  (in_flits),
    .eject_sel (eject_sel),
    .inj_avail (inj_avail),
    .inj_flit  (inj_flit),
    .vacancy   (vacancy),
    .inject_sel(inject_sel),
    .inj_pop   (inj_pop),
    .nxt_flits (nxt_flits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_flits <= '0;
      ej_valid  <= 1'b0;
      ej_flit   <= '0;
    end else begin
      out_flits <= nxt_flits;
      ej_valid  <= (ej_kind != EJK_NONE);
      ej_flit   <= ej_flit_c;
    end
  end

endmodule

// File: rtl/bdr_inject_eject_chk.sv
module bdr_inject_eject_chk #(
  parameter int NP = 4,
  parameter int FW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP*FW-1:0] in_flits,
  input logic [NP*FW-1:0] out_flits,
  input logic             ej_ready,
  input logic             ej_valid,
  input logic             inj_pop,
  input logic [NP-1:0]    local_vec,
  input logic [NP-1:0]    gold_vec,
  input logic [NP-1:0]    eject_sel,
  input logic [NP-1:0]    inject_sel
);

  logic [NP-1:0] in_v;
  logic [NP-1:0] out_v;
  logic          armed;

  for (genvar k = 0; k < NP; k++) begin : g_v
    assign in_v[k]  = in_flits[k*FW + FW - 1];
    assign out_v[k] = out_flits[k*FW + FW - 1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r4_single_eject: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eject_sel));

  a_r7_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ej_ready |-> (eject_sel == '0));

  a_r5_golden_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_ready && |(local_vec & gold_vec)) |-> |(eject_sel & gold_vec));

  a_r9_no_displace: assert property (@(posedge clk) disable iff (!rst_n)
    (inject_sel & in_v & ~eject_sel) == '0);

  a_r3_eject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (ej_valid == $past(|eject_sel)));

  a_r8_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($countones(out_v) ==
               $countones($past(in_v)) - $countones($past(eject_sel)) + int'($past(inj_pop))));

endmodule

bind bdr_inject_eject bdr_inject_eject_chk #(.NP(NP), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_flits  (in_flits),
  .out_flits (out_flits),
  .ej_ready  (ej_ready),
  .ej_valid  (ej_valid),
  .inj_pop   (inj_pop),
  .local_vec (local_vec),
  .gold_vec  (gold_vec),
  .eject_sel (eject_sel),
  .inject_sel(inject_sel)
);

// File: tb/sim_bdr_inject_eject.sv
`timescale 1ns/1ps
module sim_bdr_inject_eject;

  localparam int NP = 4;
  localparam int DW = 6;
  localparam int PW = 16;
  localparam int HID = 5;
  localparam int FW = 2 + DW + PW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP*FW-1:0] in_flits = '0;
  logic             inj_avail = 1'b0;
  logic [FW-1:0]    inj_flit = '0;
  logic             inj_pop;
  logic             ej_ready = 1'b0;
  logic             ej_valid;
  logic [FW-1:0]    ej_flit;
  logic [NP*FW-1:0] out_flits;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bdr_inject_eject #(.NP(NP), .DW(DW), .PW(PW), .HOME_ID(HID)) u0 (
    .clk(clk), .rst_n(rst_n), .in_flits(in_flits), .inj_avail(inj_avail),
    .inj_flit(inj_flit), .inj_pop(inj_pop), .ej_ready(ej_ready),
    .ej_valid(ej_valid), .ej_flit(ej_flit), .out_flits(out_flits)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input bit v, input bit g, input int d, input int p);
    return {v, g, DW'(d), PW'(p)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] slot [NP];
    logic [FW-1:0] exp_out [NP];
    logic [FW-1:0] exp_ej;
    int            pick;
    int            ins;
    bit            rdy, av;
    string         tag;

    repeat (3) @(negedge clk);
    // R1: reset state, during reset
    chk(out_flits == '0, "R1", 64'(out_flits[FW-1:0]), 0);
    chk(ej_valid == 1'b0, "R1", 64'(ej_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first cycle after reset
    chk(out_flits == '0 && ej_valid == 1'b0 && ej_flit == '0, "R1",
        64'(ej_valid), 0);

    for (int v = 0; v < 1024; v++) begin
      rdy = v[8];
      av  = v[9];
      for (int k = 0; k < NP; k++) begin
        int s;
        s = (v >> (2 * k)) & 3;
        case (s)
          0: slot[k] = mk(0, k[0], HID, 16'h1111 * (k + 1) + v);
          1: slot[k] = mk(1, v[k], (HID + k + 1) % 64, 16'hA000 + v * 4 + k);
          2: slot[k] = mk(1, 0, HID, 16'hB000 + v * 4 + k);
          default: slot[k] = mk(1, 1, HID, 16'hC000 + v * 4 + k);
        endcase
      end

      // bench model: ejection choice
      pick = -1;
      if (rdy) begin
        for (int k = NP - 1; k >= 0; k--)
          if (slot[k][FW-1] && slot[k][PW +: DW] == DW'(HID) && !slot[k][FW-2]) pick = k;
        for (int k = NP - 1; k >= 0; k--)
          if (slot[k][FW-1] && slot[k][PW +: DW] == DW'(HID) && slot[k][FW-2]) pick = k;
      end
      exp_ej = (pick >= 0) ? slot[pick] : '0;

      // bench model: injection slot
      ins = -1;
      for (int k = 0; k < NP; k++)
        if (ins < 0 && av && (!slot[k][FW-1] || k == pick)) ins = k;

      for (int k = 0; k < NP; k++) begin
        if (k == ins)                        exp_out[k] = {1'b1, 1'b1, DW'(HID ^ 3), PW'(v)};
        else if (k == pick || !slot[k][FW-1]) exp_out[k] = '0;
        else                                 exp_out[k] = slot[k];
      end

      for (int k = 0; k < NP; k++) in_flits[k*FW +: FW] = slot[k];
      ej_ready  = rdy;
      inj_avail = av;
      inj_flit  = {1'b0, 1'b1, DW'(HID ^ 3), PW'(v)};
      #1;
      if (!av) tag = "R10";
      else if (ins < 0) tag = "R9";
      else tag = "R8";
      chk(inj_pop == (ins >= 0), tag, 64'(inj_pop), 64'(ins >= 0));

      @(negedge clk);
      if (!rdy) tag = "R7";
      else if (pick >= 0 && slot[pick][FW-2]) tag = "R5";
      else if (pick >= 0) tag = "R6";
      else tag = "R11";
      chk(ej_valid == (pick >= 0) && ej_flit == exp_ej, tag,
          64'({ej_valid, ej_flit}), 64'({pick >= 0, exp_ej}));

      for (int k = 0; k < NP; k++) begin
        if (k == ins) tag = "R8";
        else if (k == pick) tag = "R3";
        else if (!slot[k][FW-1]) tag = "R10";
        else if (slot[k][PW +: DW] == DW'(HID)) tag = rdy ? "R4" : "R7";
        else tag = "R2";
        chk(out_flits[k*FW +: FW] == exp_out[k], tag,
            64'(out_flits[k*FW +: FW]), 64'(exp_out[k]));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule